// File: doc/BRIEF.md
# Serial Link Latency Calculator

This block converts the raw timing figures captured on a radio-interface serial link into the two total latencies a timing controller needs. One figure is the transmit latency from the core fabric to the serial pins. The other is the receive latency from the pins back to the core. The inputs are:

- two fractional delay counts measured in sampling-clock cycles;
- the alignment counts captured when the link came up;
- a 2-bit code that selects the line-rate group;
- the unit-interval period in femtoseconds.

Software or a controller sets these inputs and pulses `start_i`. A few cycles later `done_o` pulses once, and both signed results, in femtoseconds, are then held on the outputs.

Each delay count is in 1/256-cycle units. The block scales it by the sampling-clock period (default 4 ns) and divides by 256. It adds a signed number of unit intervals that depends on the rate group. For the receive side, that number also includes an alignment correction. The correction is one of three things, depending on the rate group:

- a low-rate slip count, which is added;
- a wrapped high-rate slip count, which is added;
- a codeword position, which is subtracted.

All four products go through one registered multiplier, one product per cycle.

Top module: `link_lat_calc`

## Requirements
- R1: While `rst_i` is high, and in the first cycle after it, `busy_o` and `done_o` are 0 and both latency outputs are 0.
- R2: A `start_i` sampled while `busy_o` is low begins a computation. `busy_o` is high from the next cycle. `done_o` is high exactly six clock edges after the accepting edge, counting that edge.
- R3: `done_o` is high for a single cycle per computation.
- R4: The transmit result equals floor(tx_dly × 4 000 000 / 256) fs plus the unit interval times 365, 367, 569 or 537. These apply to rate codes 0 (low rates), 1 (middle rates), 2 (high rates without FEC) and 3 (high rates with FEC), in that order. Delay bits [20:8] are whole cycles and bits [7:0] are 1/256 cycle.
- R5: For rate codes 0 and 1, the receive result equals the scaled rx_dly plus (255 + slip_lo) unit intervals.
- R6: For rate code 2, the receive result equals the scaled rx_dly plus (−347 + s) unit intervals. If the 7-bit slip_hi is 63 or more, s = 66 − slip_hi. Otherwise s = slip_hi.
- R7: For rate code 3, the receive result equals the scaled rx_dly plus (−315 − cw_pos) unit intervals, so the codeword position is subtracted.
- R8: Every input is sampled only at the accepting edge. Changes to any input while `busy_o` is high have no effect on the results.
- R9: The latency outputs change only in the cycle in which `done_o` is high, and they keep their values between computations.
- R10: `start_i` is ignored while `busy_o` is high. It neither restarts the computation nor produces an extra `done_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begin a computation (ignored while busy) |
| rate_i | input | 2 | Rate group: 0 low, 1 middle, 2 high without FEC, 3 high with FEC |
| tx_dly_i | input | 21 | Transmit delay, sampling cycles, 8 fractional bits |
| rx_dly_i | input | 21 | Receive delay, sampling cycles, 8 fractional bits |
| slip_lo_i | input | 5 | Bit-slip count, rate codes 0 and 1 |
| slip_hi_i | input | 7 | Raw bit-slip count, rate code 2 |
| cw_pos_i | input | 5 | Codeword position, rate code 3 |
| ui_fs_i | input | 20 | Unit-interval period in femtoseconds |
| busy_o | output | 1 | Computation in progress |
| done_o | output | 1 | One-cycle pulse when both results are valid |
| tx_lat_o | output | 48 | Signed transmit latency, femtoseconds |
| rx_lat_o | output | 48 | Signed receive latency, femtoseconds |

## Verification
The end of one computation and the acceptance of the next can fall in the same cycle. `busy_o` drops in the `done_o` cycle, so a controller that restarts at once has its new `start_i` sampled while the old results are being handed over. The scoreboard driver always issues the next start in the first cycle where busy is low, which is the done cycle. It also holds `start_i` high for several busy cycles and scrambles every input after acceptance. The monitor then requires one result per accepted start, in order, with correct values. It also requires the outputs to stay unchanged in every cycle other than a done cycle.

// File: rtl/lat_pkg.sv
package lat_pkg;

  typedef enum logic [1:0] {
    RATE_LOW    = 2'd0,
    RATE_MID    = 2'd1,
    RATE_HI     = 2'd2,
    RATE_HI_FEC = 2'd3
  } rate_e;

  // width of the signed unit-interval coefficients
  localparam int COEF_W = 12;

  // transmit offsets in unit intervals
  localparam int TX_UI_LOW = 365;
  localparam int TX_UI_MID = 367;
  localparam int TX_UI_HI  = 569;
  localparam int TX_UI_FEC = 537;

  // receive base offsets in unit intervals
  localparam int RX_UI_LM  = 255;
  localparam int RX_UI_HI  = -347;
  localparam int RX_UI_FEC = -315;

  // high-rate slip counts wrap around the 66-bit block
  localparam int SLIP_WRAP    = 66;
  localparam int SLIP_FOLD_AT = 63;

endpackage

// File: rtl/lat_coef.sv
module lat_coef
  import lat_pkg::*;
#(
  parameter int LO_W = 5,
  parameter int HI_W = 7,
  parameter int CW_W = 5
) (
  input  rate_e                     rate_i,
  input  logic [LO_W-1:0]           slip_lo_i,
  input  logic [HI_W-1:0]           slip_hi_i,
  input  logic [CW_W-1:0]           cw_pos_i,
  output logic signed [COEF_W-1:0]  tx_coef_o,
  output logic signed [COEF_W-1:0]  rx_coef_o
);

  logic signed [COEF_W-1:0] hi_fold;

  // wrap a large slip count back into a signed correction
  always_comb begin
    if (int'(slip_hi_i) >= SLIP_FOLD_AT)
      hi_fold = COEF_W'(SLIP_WRAP) - COEF_W'(slip_hi_i);
    else
      hi_fold = COEF_W'(slip_hi_i);
  end

  always_comb begin
    case (rate_i)
      RATE_LOW: begin
        tx_coef_o = COEF_W'(TX_UI_LOW);
        rx_coef_o = COEF_W'(RX_UI_LM) + COEF_W'(slip_lo_i);
      end
      RATE_MID: begin
        tx_coef_o = COEF_W'(TX_UI_MID);
        rx_coef_o = COEF_W'(RX_UI_LM) + COEF_W'(slip_lo_i);
      end
      RATE_HI: begin
        tx_coef_o = COEF_W'(TX_UI_HI);
        rx_coef_o = COEF_W'(RX_UI_HI) + hi_fold;
      end
      default: begin
        tx_coef_o = COEF_W'(TX_UI_FEC);
        rx_coef_o = COEF_W'(RX_UI_FEC) - COEF_W'(cw_pos_i);
      end
    endcase
  end

endmodule

// File: rtl/lat_mac.sv
module lat_mac #(
  parameter int AW    = 21,
  parameter int BW    = 24,
  parameter int TAG_W = 2,
  localparam int PW   = AW + BW + 1
) (
  input  logic                 clk_i,
  input  logic                 rst_i,
  input  logic                 vld_i,
  input  logic [TAG_W-1:0]     tag_i,
  input  logic [AW-1:0]        a_i,
  input  logic signed [BW-1:0] b_i,
  output logic                 vld_o,
  output logic [TAG_W-1:0]     tag_o,
  output logic signed [PW-1:0] p_o
);

  logic signed [PW-1:0] a_ext;
  logic signed [PW-1:0] b_ext;

  assign a_ext = PW'($signed({1'b0, a_i}));
  assign b_ext = PW'(b_i);

  // one product register, inferable into a DSP slice
  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      vld_o <= 1'b0;
      tag_o <= '0;
      p_o   <= '0;
    end else begin
      vld_o <= vld_i;
      if (vld_i) begin
        tag_o <= tag_i;
        p_o   <= a_ext * b_ext;
      end
    end
  end

  // R2: every issued operand pair yields a product on the next cycle
  a_r2_mac_pipe: assert property (@(posedge clk_i) disable iff (rst_i)
    vld_i |=> vld_o);

endmodule

// File: rtl/link_lat_calc.sv
module link_lat_calc
  import lat_pkg::*;
#(
  parameter int DLY_W   = 21,
  parameter int FRAC_W  = 8,
  parameter int UI_W    = 20,
  parameter int LO_W    = 5,
  parameter int HI_W    = 7,
  parameter int CW_W    = 5,
  parameter int SAMP_FS = 4000000,
  parameter int SAMP_W  = 24,
  parameter int OUT_W   = 48
) (
  input  logic                    clk_i,
  input  logic                    rst_i,
  input  logic                    start_i,
  input  logic [1:0]              rate_i,
  input  logic [DLY_W-1:0]        tx_dly_i,
  input  logic [DLY_W-1:0]        rx_dly_i,
  input  logic [LO_W-1:0]         slip_lo_i,
  input  logic [HI_W-1:0]         slip_hi_i,
  input  logic [CW_W-1:0]         cw_pos_i,
  input  logic [UI_W-1:0]         ui_fs_i,
  output logic                    busy_o,
  output logic                    done_o,
  output logic signed [OUT_W-1:0] tx_lat_o,
  output logic signed [OUT_W-1:0] rx_lat_o
);

  localparam int AW    = (DLY_W > UI_W) ? DLY_W : UI_W;
  localparam int BW    = SAMP_W;
  localparam int PW    = AW + BW + 1;
  localparam int TAG_W = 2;
  localparam int NOPS  = 4;
  localparam int CNT_W = 3;

  // operation order through the shared multiplier
  localparam logic [TAG_W-1:0] OP_TX_DLY = 2'd0;
  localparam logic [TAG_W-1:0] OP_TX_UI  = 2'd1;
  localparam logic [TAG_W-1:0] OP_RX_DLY = 2'd2;
  localparam logic [TAG_W-1:0] OP_RX_UI  = 2'd3;

  // latched operands
  logic [1:0]       rate_q;
  logic [DLY_W-1:0] tx_dly_q, rx_dly_q;
  logic [LO_W-1:0]  slip_lo_q;
  logic [HI_W-1:0]  slip_hi_q;
  logic [CW_W-1:0]  cw_pos_q;
  logic [UI_W-1:0]  ui_q;

  logic             busy_q;
  logic             done_q;
  logic [CNT_W-1:0] cnt_q;
  logic             accept;
  logic             issue;

  logic signed [COEF_W-1:0] tx_coef, rx_coef;
  logic [AW-1:0]            mul_a;
  logic signed [BW-1:0]     mul_b;
  logic                     mac_vld;
  logic [TAG_W-1:0]         mac_tag;
  logic signed [PW-1:0]     mac_p;

  logic signed [OUT_W-1:0] tx_acc, rx_acc;
  logic signed [OUT_W-1:0] tx_lat_q, rx_lat_q;

  function automatic logic signed [OUT_W-1:0] widen(input logic signed [PW-1:0] v);
    return OUT_W'(v);
  endfunction

  assign accept = start_i && !busy_q;
  assign issue  = busy_q && (int'(cnt_q) < NOPS);

  lat_coef #(
    .LO_W (LO_W),
    .HI_W (HI_W),
    .CW_W (CW_W)
  ) u_coef (
    .rate_i    (rate_e'(rate_q)),
    .slip_lo_i (slip_lo_q),
    .slip_hi_i (slip_hi_q),
    .cw_pos_i  (cw_pos_q),
    .tx_coef_o (tx_coef),
    .rx_coef_o (rx_coef)
  );

  // operand selection for the current step
  always_comb begin
    case (cnt_q[TAG_W-1:0])
      OP_TX_DLY: begin mul_a = AW'(tx_dly_q); mul_b = BW'(SAMP_FS); end
      OP_TX_UI:  begin mul_a = AW'(ui_q);     mul_b = BW'(tx_coef); end
      OP_RX_DLY: begin mul_a = AW'(rx_dly_q); mul_b = BW'(SAMP_FS); end
      default:   begin mul_a = AW'(ui_q);     mul_b = BW'(rx_coef); end
    endcase
  end

  lat_mac #(
    .AW    (AW),
    .BW    (BW),
    .TAG_W (TAG_W)
  ) u_mac (
    .clk_i (clk_i),
    .rst_i (rst_i),
    .vld_i (issue),
    .tag_i (cnt_q[TAG_W-1:0]),
    .a_i   (mul_a),
    .b_i   (mul_b),
    .vld_o (mac_vld),
    .tag_o (mac_tag),
    .p_o   (mac_p)
  );

  // input capture and step counter
  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      rate_q    <= '0;
      tx_dly_q  <= '0;
      rx_dly_q  <= '0;
      slip_lo_q <= '0;
      slip_hi_q <= '0;
      cw_pos_q  <= '0;
      ui_q      <= '0;
      cnt_q     <= CNT_W'(NOPS);
    end else if (accept) begin
      rate_q    <= rate_i;
      tx_dly_q  <= tx_dly_i;
      rx_dly_q  <= rx_dly_i;
      slip_lo_q <= slip_lo_i;
      slip_hi_q <= slip_hi_i;
      cw_pos_q  <= cw_pos_i;
      ui_q      <= ui_fs_i;
      cnt_q     <= '0;
    end else if (issue) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  // accumulation and result hand-over
  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      busy_q   <= 1'b0;
      done_q   <= 1'b0;
      tx_acc   <= '0;
      rx_acc   <= '0;
      tx_lat_q <= '0;
      rx_lat_q <= '0;
    end else begin
      done_q <= 1'b0;
      if (accept) busy_q <= 1'b1;
      if (mac_vld) begin
        case (mac_tag)
          OP_TX_DLY: tx_acc <= widen(mac_p >>> FRAC_W);
          OP_TX_UI:  tx_acc <= tx_acc + widen(mac_p);
          OP_RX_DLY: rx_acc <= widen(mac_p >>> FRAC_W);
          default: begin
            tx_lat_q <= tx_acc;
            rx_lat_q <= rx_acc + widen(mac_p);
            done_q   <= 1'b1;
            busy_q   <= 1'b0;
          end
        endcase
      end
    end
  end

  assign busy_o   = busy_q;
  assign done_o   = done_q;
  assign tx_lat_o = tx_lat_q;
  assign rx_lat_o = rx_lat_q;

  // R1: reset leaves everything idle and zeroed
  a_r1_reset_idle: assert property (@(posedge clk_i)
    rst_i |=> (!busy_o && !done_o && tx_lat_o == '0 && rx_lat_o == '0));

  // R2: done follows the accepting edge by a fixed latency
  a_r2_done_latency: assert property (@(posedge clk_i) disable iff (rst_i)
    done_o |-> $past(start_i && !busy_o, 6));

  // R2: acceptance raises busy
  a_r2_busy_rise: assert property (@(posedge clk_i) disable iff (rst_i)
    (start_i && !busy_o) |=> busy_o);

  // R3: single-cycle done
  a_r3_done_pulse: assert property (@(posedge clk_i) disable iff (rst_i)
    done_o |=> !done_o);

  // R9: results held outside the done cycle
  a_r9_hold: assert property (@(posedge clk_i) disable iff (rst_i)
    !done_o |-> ($stable(tx_lat_o) && $stable(rx_lat_o)));

  // R10: a start while busy never rewinds the step counter
  a_r10_no_restart: assert property (@(posedge clk_i) disable iff (rst_i)
    (busy_q && start_i) |=> (cnt_q != '0));

endmodule

// File: tb/sim_link_lat_calc.sv
`timescale 1ns/1ps
module sim_link_lat_calc;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic [1:0]  rate = '0;
  logic [20:0] tx_dly = '0, rx_dly = '0;
  logic [4:0]  slip_lo = '0, cw_pos = '0;
  logic [6:0]  slip_hi = '0;
  logic [19:0] ui_fs = '0;
  logic busy, done;
  logic signed [47:0] tx_lat, rx_lat;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  longint q_tx[$];
  longint q_rx[$];
  string  q_req[$];
  longint last_tx = 0, last_rx = 0;

  always #5 clk = ~clk;

  link_lat_calc u0 (
    .clk_i(clk), .rst_i(rst), .start_i(start), .rate_i(rate),
    .tx_dly_i(tx_dly), .rx_dly_i(rx_dly), .slip_lo_i(slip_lo),
    .slip_hi_i(slip_hi), .cw_pos_i(cw_pos), .ui_fs_i(ui_fs),
    .busy_o(busy), .done_o(done), .tx_lat_o(tx_lat), .rx_lat_o(rx_lat)
  );

  function automatic longint exp_tx(int v, longint d, longint ui);
    longint off;
    off = (v == 0) ? 365 : (v == 1) ? 367 : (v == 2) ? 569 : 537;
    return (d * 4000000) / 256 + ui * off;
  endfunction

  function automatic longint exp_rx(int v, longint d, longint slo, longint shi,
                                    longint cw, longint ui);
    longint c;
    if (v < 2)       c = 255 + slo;
    else if (v == 2) c = -347 + ((shi >= 63) ? 66 - shi : shi);
    else             c = -315 - cw;
    return (d * 4000000) / 256 + ui * c;
  endfunction

  task automatic check(string req, string what, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // driver: push expectation, pulse start, then scramble inputs while busy
  task automatic calc(string req, int v, int txd, int rxd, int slo, int shi,
                      int cw, int ui, int hold);
    @(negedge clk);
    while (busy) @(negedge clk);
    rate = 2'(v); tx_dly = 21'(txd); rx_dly = 21'(rxd);
    slip_lo = 5'(slo); slip_hi = 7'(shi); cw_pos = 5'(cw); ui_fs = 20'(ui);
    start = 1'b1;
    q_tx.push_back(exp_tx(v, txd, ui));
    q_rx.push_back(exp_rx(v, rxd, slo, shi, cw, ui));
    q_req.push_back(req);
    repeat (hold) @(negedge clk);
    start = 1'b0;
    // R8: these changes during busy must not reach the results
    rate = ~rate; tx_dly = ~tx_dly; rx_dly = rx_dly ^ 21'h15A5A;
    slip_lo = ~slip_lo; slip_hi = ~slip_hi; cw_pos = ~cw_pos;
    ui_fs = ui_fs ^ 20'h5A5A5;
  endtask

  // monitor: pop and compare on done, otherwise demand held outputs
  always @(negedge clk) begin
    if (!rst && !finished) begin
      if (done) begin
        if (q_tx.size() == 0) begin
          checks++; errors++;
          $display("FAIL R10 extra done actual=1 expected=0");
        end else begin
          string r;
          longint et, er;
          r = q_req.pop_front(); et = q_tx.pop_front(); er = q_rx.pop_front();
          check(r, "tx", longint'(tx_lat), et);
          check(r, "rx", longint'(rx_lat), er);
        end
        last_tx = longint'(tx_lat);
        last_rx = longint'(rx_lat);
      end else begin
        check("R9", "tx hold", longint'(tx_lat), last_tx);
        check("R9", "rx hold", longint'(rx_lat), last_rx);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: idle and zero during reset
    check("R1", "busy", longint'(busy), 0);
    check("R1", "done", longint'(done), 0);
    check("R1", "tx", longint'(tx_lat), 0);
    check("R1", "rx", longint'(rx_lat), 0);
    rst = 1'b0;
    @(negedge clk);
    check("R1", "busy after", longint'(busy), 0);

    // R2 latency: accepted at the next edge, done six edges later
    @(negedge clk);
    rate = 2'd0; tx_dly = 21'h27F4; rx_dly = 21'h1A80; slip_lo = 5'd7;
    ui_fs = 20'd406901; start = 1'b1;
    q_tx.push_back(exp_tx(0, 21'h27F4, 406901));
    q_rx.push_back(exp_rx(0, 21'h1A80, 7, 0, 0, 406901));
    q_req.push_back("R4/R5");
    @(negedge clk); start = 1'b0;
    check("R2", "busy", longint'(busy), 1);
    repeat (4) @(negedge clk);
    check("R2", "done early", longint'(done), 0);
    @(negedge clk);
    check("R2", "done", longint'(done), 1);

    calc("R4/R5 mid max", 1, 21'h1FFFFF, 0, 31, 0, 0, 101725, 1);
    calc("R6 slip 10", 2, 21'h0123, 21'h0456, 0, 10, 0, 98643, 1);
    calc("R6 slip 63", 2, 21'h0800, 21'h0100, 0, 63, 0, 98643, 1);
    calc("R6 slip 62", 2, 21'h0800, 21'h0100, 0, 62, 0, 98643, 1);
    calc("R6 slip 127", 2, 0, 0, 0, 127, 0, 41101, 1);
    calc("R7 cw 0", 3, 21'h10001, 21'h00FF, 0, 0, 0, 41101, 1);
    calc("R7 cw 31", 3, 21'h10001, 21'h00FF, 0, 0, 31, 41101, 1);
    calc("R10 held start", 0, 21'h00C0, 21'h0333, 0, 0, 0, 406901, 3);
    calc("R8 scramble", 1, 21'h0A0A0, 21'h05050, 12, 99, 17, 101725, 4);
    calc("R4 low zero", 0, 0, 0, 0, 0, 0, 0, 1);

    repeat (12) @(negedge clk);
    // R10: one done per accepted start
    check("R10", "pending", longint'(q_tx.size()), 0);
    if (!finished) begin
      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule